// File: doc/BRIEF.md
# Smart-card character receiver

This block receives characters from a half-duplex smart-card style serial line. Each character is a low start bit, eight data bits sent least significant bit first, one parity bit and a high stop bit. The block has two clocking modes. In the asynchronous mode the line is timed from the system clock with `OSR` clocks per bit, and each bit is sampled at its centre. In the clock-synchronized mode an external bit clock is brought in through a synchronizer, and the line is sampled on each rising edge of that clock.

When the stop bit is sampled, the character moves into a four-entry first-in first-out buffer, and its parity is judged at that same moment. The buffer reports its fill level and a full flag. It raises a level interrupt once the fill reaches a programmable threshold, and a one-cycle overrun pulse when a character arrives with nowhere to go.

A parity failure always sets a sticky error flag. In T=0 behaviour the receiver also pulls its line-drive output low for a short error window after the stop bit. In T=1 behaviour that output stays released.

Top module: `smartcard_rx`

## Requirements
- R1: In asynchronous mode (`async_mode`=1), a low level on `rx_in` starts a character once it has passed a two-flop synchronizer. The line is checked again OSR/2 clocks later. If it has gone high again, the event is dropped and nothing is stored. Every later bit lasts OSR clocks and is sampled at its centre.
- R2: After the start bit come eight data bits, least significant first, then the parity bit. The stop-bit sample stores the eight data bits at the buffer tail.
- R3: In clock-synchronized mode (`async_mode`=0), the first rising edge of `sclk_in` that finds `rx_in` low is taken as the start bit. Each later rising edge samples one bit, in the order given in R2.
- R4: The buffer returns characters oldest first on `rd_data`. A one-cycle `rd_en` removes the oldest character and lowers `rx_count` by one. `rd_en` on an empty buffer has no effect.
- R5: `rx_irq` is high exactly while `rx_thresh` is nonzero and `rx_count` is at least `rx_thresh`. A threshold of 0 keeps `rx_irq` low.
- R6: `rx_full` is high exactly while the buffer holds 4 characters.
- R7: A character completed while the buffer is full, with no read in that cycle, is dropped. The stored characters stay unchanged, and `ovr_irq` pulses high for one cycle.
- R8: Parity is even when `odd_parity`=0 and odd when `odd_parity`=1. A character is in error when the XOR of its eight data bits and its parity bit differs from `odd_parity`. An error sets `perr_flag` at the stop sample. The flag stays set until `perr_clr`, and a new error wins over a clear in the same cycle.
- R9: With `proto_t1`=0 and a parity error, `nack_n` goes low half a bit after the stop-bit sample and stays low for 1.5 bit times (OSR+OSR/2 clocks), then returns high.
- R10: With `proto_t1`=1, `nack_n` stays high even when parity fails, and `perr_flag` is still set.
- R11: A character with a parity error is stored in the buffer like any other.
- R12: If a character completes in the same cycle as a read, and the buffer is full, no overrun is raised. The oldest character leaves, the new one enters at the tail, and `rx_count` stays 4.
- R13: After reset, `rx_count`=0, `rx_full`=0, `rx_irq`=0, `ovr_irq`=0, `perr_flag`=0 and `nack_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| async_mode | input | 1 | 1: oversampled timing, 0: external bit clock |
| proto_t1 | input | 1 | 1: T=1 behaviour (no error pulse), 0: T=0 behaviour |
| odd_parity | input | 1 | 1: odd parity, 0: even parity |
| rx_thresh | input | CNT_W | Fill level that raises `rx_irq`; 0 disables it |
| sclk_in | input | 1 | External bit clock for the synchronized mode |
| rx_in | input | 1 | Serial line, idle high |
| rd_en | input | 1 | Removes the oldest stored character |
| perr_clr | input | 1 | Clears the sticky parity error flag |
| rd_data | output | 8 | Oldest stored character |
| rx_count | output | CNT_W | Number of stored characters |
| rx_full | output | 1 | Buffer holds DEPTH characters |
| rx_irq | output | 1 | Fill level at or above the threshold |
| ovr_irq | output | 1 | One-cycle pulse when a character is dropped |
| perr_flag | output | 1 | Sticky parity error flag |
| nack_n | output | 1 | Line drive; 0 pulls the line low for the error signal |

## Verification
The buffer write triggered by the stop sample can land in the same clock as a software read. The most delicate case is when the buffer is full, because the write and the read then decide together whether an overrun happens. The bench fills the buffer, computes from the bit timing the exact clock in which the stop bit is sampled, and raises `rd_en` for that single cycle only. The result is judged in three ways: no overrun pulse may appear, the fill must stay at four, and the four characters read out afterwards must be the three younger ones followed by the new one.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;

  localparam int unsigned SC_DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_DATA,
    ST_STOP,
    ST_NWAIT,
    ST_NACK
  } sc_state_t;

  // True when data plus parity bit break the selected parity sense.
  function automatic logic parity_fault(input logic [SC_DATA_W:0] bits,
                                        input logic odd_sel);
    return (^bits) ^ odd_sel;
  endfunction

  // Fill-level interrupt; a zero threshold disables it.
  function automatic logic level_reached(input int unsigned count,
                                         input int unsigned thresh);
    return (thresh != 0) && (count >= thresh);
  endfunction

endpackage

// File: rtl/sc_tick_gen.sv
module sc_tick_gen #(
  parameter int unsigned OSR = 8,
  localparam int unsigned PH_W = $clog2(OSR),
  localparam int unsigned HALF = OSR / 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_mode,
  input  logic sclk_s,
  input  logic restart,
  output logic samp_tick,
  output logic half_tick
);

  logic [PH_W-1:0] phase;
  logic            sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= '0;
      sclk_q <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      if (restart || phase == PH_W'(OSR - 1)) phase <= '0;
      else                                    phase <= phase + 1'b1;
    end
  end

  // Async: sample at bit centre, boundary at phase wrap.
  // Synchronized: sample on rising, boundary on falling bit clock.
  assign samp_tick = async_mode ? (phase == PH_W'(HALF - 1)) : (sclk_s & ~sclk_q);
  assign half_tick = async_mode ? (phase == PH_W'(OSR - 1))  : (~sclk_s & sclk_q);

endmodule

// File: rtl/sc_frame_rx.sv
module sc_frame_rx
  import sc_rx_pkg::*;
#(
  parameter int unsigned NACK_HALVES = 3,
  localparam int unsigned NC_W = $clog2(NACK_HALVES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 async_mode,
  input  logic                 proto_t1,
  input  logic                 odd_parity,
  input  logic                 rx_s,
  input  logic                 samp_tick,
  input  logic                 half_tick,
  output logic                 restart,
  output logic                 commit,
  output logic [SC_DATA_W-1:0] commit_data,
  output logic                 commit_perr,
  output logic                 nack_n
);

  sc_state_t         state;
  logic [3:0]        bitcnt;
  logic [SC_DATA_W:0] sreg;
  logic [NC_W-1:0]   ncnt;

  assign restart     = async_mode && (state == ST_IDLE) && !rx_s;
  assign commit      = (state == ST_STOP) && samp_tick;
  assign commit_data = sreg[SC_DATA_W-1:0];
  assign commit_perr = parity_fault(sreg, odd_parity);
  assign nack_n      = (state != ST_NACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      sreg   <= '0;
      ncnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (async_mode) begin
            if (!rx_s) state <= ST_HUNT;
          end else if (samp_tick && !rx_s) begin
            state  <= ST_DATA;
            bitcnt <= '0;
          end
        end
        ST_HUNT: begin
          if (samp_tick) begin
            if (!rx_s) begin
              state  <= ST_DATA;
              bitcnt <= '0;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_DATA: begin
          if (samp_tick) begin
            sreg <= {rx_s, sreg[SC_DATA_W:1]};
            if (bitcnt == 4'(SC_DATA_W)) state <= ST_STOP;
            else                         bitcnt <= bitcnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (samp_tick) begin
            if (commit_perr && !proto_t1) state <= ST_NWAIT;
            else                          state <= ST_IDLE;
          end
        end
        ST_NWAIT: begin
          if (half_tick) begin
            state <= ST_NACK;
            ncnt  <= '0;
          end
        end
        ST_NACK: begin
          if (samp_tick || half_tick) begin
            if (ncnt == NC_W'(NACK_HALVES - 1)) state <= ST_IDLE;
            else                                ncnt  <= ncnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sc_rx_fifo.sv
module sc_rx_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     rd_data,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             dropped
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_pop, do_push;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CNT_W'(DEPTH));
  assign do_pop  = pop && (count != '0);
  assign do_push = push && (!full || do_pop);
  assign dropped = push && !do_push;
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/smartcard_rx.sv
module smartcard_rx
  import sc_rx_pkg::*;
#(
  parameter int unsigned OSR         = 8,
  parameter int unsigned DEPTH       = 4,
  parameter int unsigned NACK_HALVES = 3,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 async_mode,
  input  logic                 proto_t1,
  input  logic                 odd_parity,
  input  logic [CNT_W-1:0]     rx_thresh,
  input  logic                 sclk_in,
  input  logic                 rx_in,
  input  logic                 rd_en,
  input  logic                 perr_clr,
  output logic [SC_DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]     rx_count,
  output logic                 rx_full,
  output logic                 rx_irq,
  output logic                 ovr_irq,
  output logic                 perr_flag,
  output logic                 nack_n
);

  logic [1:0]           rx_sync, sclk_sync;
  logic                 samp_tick, half_tick, restart;
  logic                 commit_evt, commit_perr, drop_evt;
  logic [SC_DATA_W-1:0] commit_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sync   <= 2'b11;
      sclk_sync <= 2'b00;
    end else begin
      rx_sync   <= {rx_sync[0], rx_in};
      sclk_sync <= {sclk_sync[0], sclk_in};
    end
  end

  sc_tick_gen #(.OSR(OSR)) u_ticks (
    .clk        (clk),
    .rst_n      (rst_n),
    .async_mode (async_mode),
    .sclk_s     (sclk_sync[1]),
    .restart    (restart),
    .samp_tick  (samp_tick),
    .half_tick  (half_tick)
  );

  sc_frame_rx #(.NACK_HALVES(NACK_HALVES)) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .async_mode  (async_mode),
    .proto_t1    (proto_t1),
    .odd_parity  (odd_parity),
    .rx_s        (rx_sync[1]),
    .samp_tick   (samp_tick),
    .half_tick   (half_tick),
    .restart     (restart),
    .commit      (commit_evt),
    .commit_data (commit_data),
    .commit_perr (commit_perr),
    .nack_n      (nack_n)
  );

  sc_rx_fifo #(.DEPTH(DEPTH), .W(SC_DATA_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (commit_evt),
    .push_data (commit_data),
    .pop       (rd_en),
    .rd_data   (rd_data),
    .count     (rx_count),
    .full      (rx_full),
    .dropped   (drop_evt)
  );

  assign rx_irq = level_reached(32'(rx_count), 32'(rx_thresh));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_irq   <= 1'b0;
      perr_flag <= 1'b0;
    end else begin
      ovr_irq <= drop_evt;
      if (commit_evt && commit_perr) perr_flag <= 1'b1;
      else if (perr_clr)             perr_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/sc_rx_checker.sv
module sc_rx_checker #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] rx_count,
  input logic             rx_full,
  input logic             rx_irq,
  input logic             ovr_irq,
  input logic             perr_flag,
  input logic             perr_clr,
  input logic             nack_n,
  input logic             proto_t1,
  input logic             commit,
  input logic             rd_en
);

  p_count_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CNT_W'(DEPTH));

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == $past(rx_count)) ||
    (rx_count == $past(rx_count) + CNT_W'(1)) ||
    (rx_count + CNT_W'(1) == $past(rx_count)));

  p_empty_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == '0) |-> !rx_irq);

  p_ovr_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_irq |-> (rx_count == CNT_W'(DEPTH)));

  p_drop_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && rx_full && !rd_en) |=> ovr_irq);

  p_same_cycle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && rx_full && rd_en) |=> (!ovr_irq && rx_count == CNT_W'(DEPTH)));

  p_sticky_perr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_flag && !perr_clr) |=> perr_flag);

  p_t1_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    proto_t1 |-> nack_n);

endmodule

bind smartcard_rx sc_rx_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_count  (rx_count),
  .rx_full   (rx_full),
  .rx_irq    (rx_irq),
  .ovr_irq   (ovr_irq),
  .perr_flag (perr_flag),
  .perr_clr  (perr_clr),
  .nack_n    (nack_n),
  .proto_t1  (proto_t1),
  .commit    (commit_evt),
  .rd_en     (rd_en)
);

// File: tb/smartcard_rx_bench.sv
`timescale 1ns/1ps
module smartcard_rx_bench;

  localparam int OSR  = 8;
  localparam int HALF = OSR / 2;
  localparam int CW   = 3;
  localparam int COMMIT_EDGE = 2 + HALF + 10 * OSR;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic async_mode = 1'b1, proto_t1 = 1'b0, odd_parity = 1'b0;
  logic [CW-1:0] rx_thresh = 3'd2;
  logic sclk_in = 1'b0, rx_in = 1'b1, rd_en = 1'b0, perr_clr = 1'b0;
  logic [7:0] rd_data;
  logic [CW-1:0] rx_count;
  logic rx_full, rx_irq, ovr_irq, perr_flag, nack_n;

  int checks = 0, bad = 0;
  int cyc = 0, frame_start = 0;
  int nack_cnt = 0, nack_first = 0, ovr_cnt = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  smartcard_rx u_smartcard_rx (
    .clk(clk), .rst_n(rst_n), .async_mode(async_mode), .proto_t1(proto_t1),
    .odd_parity(odd_parity), .rx_thresh(rx_thresh), .sclk_in(sclk_in),
    .rx_in(rx_in), .rd_en(rd_en), .perr_clr(perr_clr), .rd_data(rd_data),
    .rx_count(rx_count), .rx_full(rx_full), .rx_irq(rx_irq),
    .ovr_irq(ovr_irq), .perr_flag(perr_flag), .nack_n(nack_n)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if (!nack_n) begin
      if (nack_cnt == 0) nack_first = cyc;
      nack_cnt++;
    end
    if (ovr_irq) ovr_cnt++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic even_bit(input logic [7:0] d);
    return ^d;
  endfunction

  task automatic async_frame(input logic [7:0] d, input logic p, input bit pop_at_commit);
    logic [10:0] bits;
    bits = {1'b1, p, d, 1'b0};
    @(negedge clk);
    frame_start = cyc;
    fork
      begin
        for (int i = 0; i < 11; i++) begin
          rx_in = bits[i];
          repeat (OSR) @(negedge clk);
        end
        rx_in = 1'b1;
      end
      begin
        if (pop_at_commit) begin
          repeat (COMMIT_EDGE) @(posedge clk);
          @(negedge clk); rd_en = 1'b1;
          @(negedge clk); rd_en = 1'b0;
        end
      end
    join
    repeat (3 * OSR) @(negedge clk);
  endtask

  task automatic sync_frame(input logic [7:0] d, input logic p);
    logic [10:0] bits;
    bits = {1'b1, p, d, 1'b0};
    @(negedge clk);
    for (int i = 0; i < 11; i++) begin
      rx_in = bits[i]; sclk_in = 1'b0;
      repeat (4) @(negedge clk);
      sclk_in = 1'b1;
      repeat (4) @(negedge clk);
    end
    sclk_in = 1'b0; rx_in = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic pop_expect(input string tag, input int exp);
    chk(tag, rd_data, exp);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R13 count", rx_count, 0);
    chk("R13 full", rx_full, 0);
    chk("R13 irq", rx_irq, 0);
    chk("R13 ovr", ovr_irq, 0);
    chk("R13 perr", perr_flag, 0);
    chk("R13 nack", nack_n, 1);
  endtask

  task automatic t_async_single;
    nack_cnt = 0;
    async_frame(8'hA5, even_bit(8'hA5), 1'b0);
    chk("R2 count", rx_count, 1);
    chk("R2 data", rd_data, 8'hA5);
    chk("R8 perr clean", perr_flag, 0);
    chk("R9 no nack", nack_cnt, 0);
    pop_expect("R4 pop", 8'hA5);
    chk("R4 count after pop", rx_count, 0);
  endtask

  task automatic t_false_start;
    @(negedge clk);
    rx_in = 1'b0;
    repeat (2) @(negedge clk);
    rx_in = 1'b1;
    repeat (12 * OSR) @(negedge clk);
    chk("R1 glitch ignored", rx_count, 0);
    async_frame(8'h3C, even_bit(8'h3C), 1'b0);
    chk("R1 recovers", rd_data, 8'h3C);
    pop_expect("R1 pop", 8'h3C);
  endtask

  task automatic t_threshold_order;
    rx_thresh = 3'd2;
    async_frame(8'h11, even_bit(8'h11), 1'b0);
    chk("R5 below thresh", rx_irq, 0);
    async_frame(8'h80, even_bit(8'h80), 1'b0);
    chk("R5 at thresh", rx_irq, 1);
    chk("R4 count two", rx_count, 2);
    rx_thresh = 3'd0;
    @(negedge clk);
    chk("R5 zero thresh", rx_irq, 0);
    rx_thresh = 3'd2;
    pop_expect("R4 oldest", 8'h11);
    chk("R5 drops", rx_irq, 0);
    pop_expect("R4 next", 8'h80);
  endtask

  task automatic t_overrun;
    for (int i = 0; i < 4; i++) async_frame(8'(8'h21 + i), even_bit(8'(8'h21 + i)), 1'b0);
    chk("R6 full", rx_full, 1);
    chk("R6 count", rx_count, 4);
    ovr_cnt = 0;
    async_frame(8'hEE, even_bit(8'hEE), 1'b0);
    chk("R7 ovr pulse", ovr_cnt, 1);
    chk("R7 count kept", rx_count, 4);
    for (int i = 0; i < 4; i++) pop_expect("R7 kept", 8'h21 + i);
    chk("R4 empty", rx_count, 0);
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    chk("R4 pop empty ignored", rx_count, 0);
    chk("R6 not full", rx_full, 0);
  endtask

  task automatic t_same_cycle;
    for (int i = 0; i < 4; i++) async_frame(8'(8'h41 + i), even_bit(8'(8'h41 + i)), 1'b0);
    ovr_cnt = 0;
    async_frame(8'h99, even_bit(8'h99), 1'b1);
    chk("R12 no ovr", ovr_cnt, 0);
    chk("R12 count", rx_count, 4);
    for (int i = 1; i < 4; i++) pop_expect("R12 order", 8'h41 + i);
    pop_expect("R12 new tail", 8'h99);
  endtask

  task automatic t_parity_t0;
    proto_t1 = 1'b0;
    nack_cnt = 0;
    async_frame(8'h5A, ~even_bit(8'h5A), 1'b0);
    chk("R8 perr set", perr_flag, 1);
    chk("R9 nack length", nack_cnt, OSR + HALF);
    chk("R9 nack start", nack_first - frame_start, COMMIT_EDGE + HALF + 1);
    chk("R9 released", nack_n, 1);
    chk("R11 stored", rd_data, 8'h5A);
    pop_expect("R11 pop", 8'h5A);
    @(negedge clk); perr_clr = 1'b1; @(negedge clk); perr_clr = 1'b0;
    chk("R8 clear", perr_flag, 0);
  endtask

  task automatic t_parity_t1;
    proto_t1 = 1'b1;
    nack_cnt = 0;
    async_frame(8'h0F, ~even_bit(8'h0F), 1'b0);
    chk("R10 silent", nack_cnt, 0);
    chk("R10 perr set", perr_flag, 1);
    pop_expect("R10 stored", 8'h0F);
    perr_clr = 1'b1; @(negedge clk); perr_clr = 1'b0;
    proto_t1 = 1'b0;
  endtask

  task automatic t_odd;
    odd_parity = 1'b1;
    nack_cnt = 0;
    async_frame(8'hC3, ~even_bit(8'hC3), 1'b0);
    chk("R8 odd ok", perr_flag, 0);
    chk("R8 odd no nack", nack_cnt, 0);
    pop_expect("R8 odd data", 8'hC3);
    async_frame(8'hC3, even_bit(8'hC3), 1'b0);
    chk("R8 odd bad", perr_flag, 1);
    pop_expect("R8 odd bad data", 8'hC3);
    repeat (2 * OSR) @(negedge clk);
    perr_clr = 1'b1; @(negedge clk); perr_clr = 1'b0;
    odd_parity = 1'b0;
  endtask

  task automatic t_sync;
    async_mode = 1'b0;
    repeat (4) @(negedge clk);
    sync_frame(8'h96, even_bit(8'h96));
    sync_frame(8'h01, even_bit(8'h01));
    chk("R3 count", rx_count, 2);
    pop_expect("R3 first", 8'h96);
    pop_expect("R3 second", 8'h01);
    chk("R3 perr", perr_flag, 0);
    async_mode = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_async_single();
    t_false_start();
    t_threshold_order();
    t_overrun();
    t_same_cycle();
    t_parity_t0();
    t_parity_t1();
    t_odd();
    t_sync();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule